// File: doc/BRIEF.md
# Bidirectional Ring Stop

This block is a single stop on a ring interconnect that carries traffic in a clockwise lane and a counter-clockwise lane. Each lane carries one slot per cycle. A slot has a valid flag, a destination node number and a wide payload. The stop connects the two lanes to one local agent, which can receive messages from the ring and send messages onto it.

A slot that is not addressed to this stop leaves on the same lane, unchanged, in the same cycle. The stop holds no slot storage. Only one lane may deliver to the local agent in any cycle, and the choice depends on a parity bit that flips every clock:

- The clockwise lane delivers on even cycles.
- The counter-clockwise lane delivers on odd cycles.

A slot for this stop that arrives on the wrong parity simply travels on around the ring. It is delivered when it next passes this stop on the right parity.

The local agent sends a message by raising a request. The stop sends it on the lane that gives the fewer hops to the destination. The send is accepted only if that lane's outgoing slot is free in this cycle.

Top module: `ring_stop`

## Requirements
- R1: A valid incoming slot whose destination differs from NODE_ID appears on the same lane's output in the same cycle, with the same destination and payload.
- R2: A clockwise slot addressed to NODE_ID is delivered to the agent (ej_vld_o=1, ej_dir_o=0, ej_dat_o=payload) only on even cycles, and its outgoing slot is then empty unless refilled by a send.
- R3: A counter-clockwise slot addressed to NODE_ID is delivered (ej_vld_o=1, ej_dir_o=1) only on odd cycles.
- R4: A slot addressed to NODE_ID that arrives on the ineligible parity is not delivered and is passed on unchanged on its own lane.
- R5: The parity is even in the first cycle after reset release and alternates every clock after that.
- R6: A send goes clockwise when the clockwise hop count ((dst - NODE_ID) mod NODES) is no greater than the counter-clockwise count ((NODE_ID - dst) mod NODES), and counter-clockwise otherwise. A tie goes clockwise.
- R7: A send is accepted (inj_ack_o=1, message on the chosen lane's output) only when the chosen lane's incoming slot is empty or is being delivered in that cycle. Otherwise inj_ack_o=0 and the passing slot is unchanged.
- R8: In one cycle the same lane can deliver an incoming slot to the agent and carry the agent's new message on its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cw_in_vld_i | input | 1 | Clockwise incoming slot valid |
| cw_in_dst_i | input | ID_W | Clockwise incoming destination |
| cw_in_dat_i | input | DATA_W | Clockwise incoming payload |
| cw_out_vld_o | output | 1 | Clockwise outgoing slot valid |
| cw_out_dst_o | output | ID_W | Clockwise outgoing destination |
| cw_out_dat_o | output | DATA_W | Clockwise outgoing payload |
| ccw_in_vld_i | input | 1 | Counter-clockwise incoming slot valid |
| ccw_in_dst_i | input | ID_W | Counter-clockwise incoming destination |
| ccw_in_dat_i | input | DATA_W | Counter-clockwise incoming payload |
| ccw_out_vld_o | output | 1 | Counter-clockwise outgoing slot valid |
| ccw_out_dst_o | output | ID_W | Counter-clockwise outgoing destination |
| ccw_out_dat_o | output | DATA_W | Counter-clockwise outgoing payload |
| inj_req_i | input | 1 | Agent send request |
| inj_dst_i | input | ID_W | Send destination |
| inj_dat_i | input | DATA_W | Send payload |
| inj_ack_o | output | 1 | Send accepted this cycle |
| ej_vld_o | output | 1 | Delivery to agent valid |
| ej_dir_o | output | 1 | Delivering lane, 0 clockwise, 1 counter-clockwise |
| ej_dat_o | output | DATA_W | Delivered payload |

## Verification
Delivery and sending can happen on one lane in the same cycle. The slot that frees up by being delivered is then refilled at once. The bench sets this up by waiting for an even cycle, offering a clockwise slot addressed to the stop, and raising a send whose shortest path is clockwise. It checks three things: the agent receives the old payload, inj_ack_o is high, and the clockwise output carries the new message. The same send is then repeated against a clockwise slot that is only passing through, and there it must stall and leave the slot unchanged.

// File: rtl/ring_stop_pkg.sv
package ring_stop_pkg;
  typedef enum logic {DIR_CW = 1'b0, DIR_CCW = 1'b1} dir_e;
  localparam int NUM_DIRS = 2;
endpackage

// File: rtl/ring_stop_parity.sv
module ring_stop_parity (
  input  logic clk_i,
  input  logic rst_ni,
  output logic odd_o
);
  logic odd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) odd_q <= 1'b0;
    else         odd_q <= ~odd_q;
  end
  assign odd_o = odd_q;
endmodule

// File: rtl/ring_stop_route.sv
module ring_stop_route #(
  parameter int NODES   = 16,
  parameter int NODE_ID = 0,
  localparam int ID_W   = $clog2(NODES),
  localparam int HW     = ID_W + 1
) (
  input  logic [ID_W-1:0] dst_i,
  output logic            use_cw_o
);
  localparam logic [HW-1:0] SELF = HW'(NODE_ID);
  localparam logic [HW-1:0] NUM  = HW'(NODES);

  logic [HW-1:0] dst_w, cw_hops, ccw_hops;

  always_comb begin
    dst_w    = {1'b0, dst_i};
    cw_hops  = (dst_w >= SELF) ? dst_w - SELF : dst_w + NUM - SELF;
    ccw_hops = (cw_hops == '0) ? '0 : NUM - cw_hops;
    use_cw_o = (cw_hops <= ccw_hops);
  end
endmodule

// File: rtl/ring_stop_lane.sv
module ring_stop_lane #(
  parameter int DATA_W  = 512,
  parameter int NODES   = 16,
  parameter int NODE_ID = 0,
  localparam int ID_W   = $clog2(NODES)
) (
  input  logic              in_vld_i,
  input  logic [ID_W-1:0]   in_dst_i,
  input  logic [DATA_W-1:0] in_dat_i,
  input  logic              elig_i,
  input  logic              inj_sel_i,
  input  logic [ID_W-1:0]   inj_dst_i,
  input  logic [DATA_W-1:0] inj_dat_i,
  output logic              out_vld_o,
  output logic [ID_W-1:0]   out_dst_o,
  output logic [DATA_W-1:0] out_dat_o,
  output logic              ej_o,
  output logic              inj_ok_o
);
  localparam logic [ID_W-1:0] SELF = ID_W'(NODE_ID);

  logic hit, ej, slot_free, inj_ok;

  always_comb begin
    hit       = in_vld_i && (in_dst_i == SELF);
    ej        = hit && elig_i;
    // a slot emptied by delivery may be refilled in the same cycle
    slot_free = !in_vld_i || ej;
    inj_ok    = inj_sel_i && slot_free;
    out_vld_o = inj_ok || (in_vld_i && !ej);
    out_dst_o = inj_ok ? inj_dst_i : in_dst_i;
    out_dat_o = inj_ok ? inj_dat_i : in_dat_i;
  end

  assign ej_o     = ej;
  assign inj_ok_o = inj_ok;
endmodule

// File: rtl/ring_stop.sv
module ring_stop #(
  parameter int DATA_W  = 512,
  parameter int NODES   = 16,
  parameter int NODE_ID = 0,
  localparam int ID_W   = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_in_vld_i,
  input  logic [ID_W-1:0]   cw_in_dst_i,
  input  logic [DATA_W-1:0] cw_in_dat_i,
  output logic              cw_out_vld_o,
  output logic [ID_W-1:0]   cw_out_dst_o,
  output logic [DATA_W-1:0] cw_out_dat_o,
  input  logic              ccw_in_vld_i,
  input  logic [ID_W-1:0]   ccw_in_dst_i,
  input  logic [DATA_W-1:0] ccw_in_dat_i,
  output logic              ccw_out_vld_o,
  output logic [ID_W-1:0]   ccw_out_dst_o,
  output logic [DATA_W-1:0] ccw_out_dat_o,
  input  logic              inj_req_i,
  input  logic [ID_W-1:0]   inj_dst_i,
  input  logic [DATA_W-1:0] inj_dat_i,
  output logic              inj_ack_o,
  output logic              ej_vld_o,
  output logic              ej_dir_o,
  output logic [DATA_W-1:0] ej_dat_o
);
  import ring_stop_pkg::*;

  logic par_odd;
  logic use_cw;

  logic [NUM_DIRS-1:0]             in_vld, out_vld, elig, inj_sel, ej, inj_ok;
  logic [NUM_DIRS-1:0][ID_W-1:0]   in_dst, out_dst;
  logic [NUM_DIRS-1:0][DATA_W-1:0] in_dat, out_dat;

  ring_stop_parity u_par (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .odd_o  (par_odd)
  );

  ring_stop_route #(.NODES(NODES), .NODE_ID(NODE_ID)) u_route (
    .dst_i    (inj_dst_i),
    .use_cw_o (use_cw)
  );

  assign in_vld[DIR_CW]  = cw_in_vld_i;
  assign in_dst[DIR_CW]  = cw_in_dst_i;
  assign in_dat[DIR_CW]  = cw_in_dat_i;
  assign in_vld[DIR_CCW] = ccw_in_vld_i;
  assign in_dst[DIR_CCW] = ccw_in_dst_i;
  assign in_dat[DIR_CCW] = ccw_in_dat_i;

  assign elig[DIR_CW]     = ~par_odd;
  assign elig[DIR_CCW]    = par_odd;
  assign inj_sel[DIR_CW]  = inj_req_i & use_cw;
  assign inj_sel[DIR_CCW] = inj_req_i & ~use_cw;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_lane
    ring_stop_lane #(.DATA_W(DATA_W), .NODES(NODES), .NODE_ID(NODE_ID)) u_lane (
      .in_vld_i  (in_vld[d]),
      .in_dst_i  (in_dst[d]),
      .in_dat_i  (in_dat[d]),
      .elig_i    (elig[d]),
      .inj_sel_i (inj_sel[d]),
      .inj_dst_i (inj_dst_i),
      .inj_dat_i (inj_dat_i),
      .out_vld_o (out_vld[d]),
      .out_dst_o (out_dst[d]),
      .out_dat_o (out_dat[d]),
      .ej_o      (ej[d]),
      .inj_ok_o  (inj_ok[d])
    );
  end

  assign cw_out_vld_o  = out_vld[DIR_CW];
  assign cw_out_dst_o  = out_dst[DIR_CW];
  assign cw_out_dat_o  = out_dat[DIR_CW];
  assign ccw_out_vld_o = out_vld[DIR_CCW];
  assign ccw_out_dst_o = out_dst[DIR_CCW];
  assign ccw_out_dat_o = out_dat[DIR_CCW];

  assign inj_ack_o = |inj_ok;
  assign ej_vld_o  = |ej;
  assign ej_dir_o  = ej[DIR_CCW];
  assign ej_dat_o  = ej[DIR_CCW] ? in_dat[DIR_CCW] : in_dat[DIR_CW];
endmodule

// File: rtl/ring_stop_chk.sv
module ring_stop_chk #(
  parameter int DATA_W  = 512,
  parameter int NODES   = 16,
  parameter int NODE_ID = 0,
  localparam int ID_W   = $clog2(NODES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              par_odd,
  input logic              cw_in_vld_i,
  input logic [ID_W-1:0]   cw_in_dst_i,
  input logic [DATA_W-1:0] cw_in_dat_i,
  input logic              cw_out_vld_o,
  input logic [DATA_W-1:0] cw_out_dat_o,
  input logic              ccw_in_vld_i,
  input logic [ID_W-1:0]   ccw_in_dst_i,
  input logic [DATA_W-1:0] ccw_in_dat_i,
  input logic              ccw_out_vld_o,
  input logic [DATA_W-1:0] ccw_out_dat_o,
  input logic              inj_req_i,
  input logic              inj_ack_o,
  input logic              ej_vld_o,
  input logic              ej_dir_o,
  input logic [DATA_W-1:0] ej_dat_o
);
  localparam logic [ID_W-1:0] SELF = ID_W'(NODE_ID);

  a_r2_cw_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ej_vld_o && !ej_dir_o) |-> (!par_odd && cw_in_vld_i && cw_in_dst_i == SELF
                                 && ej_dat_o == cw_in_dat_i));

  a_r3_ccw_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ej_vld_o && ej_dir_o) |-> (par_odd && ccw_in_vld_i && ccw_in_dst_i == SELF
                                && ej_dat_o == ccw_in_dat_i));

  a_r5_parity_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (par_odd != $past(par_odd)));

  // R1 / R4: a slot that is not delivered is never dropped or overwritten
  a_r4_cw_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw_in_vld_i && !(ej_vld_o && !ej_dir_o)) |-> (cw_out_vld_o && cw_out_dat_o == cw_in_dat_i));

  a_r4_ccw_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccw_in_vld_i && !(ej_vld_o && ej_dir_o)) |-> (ccw_out_vld_o && ccw_out_dat_o == ccw_in_dat_i));

  a_r7_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_ack_o |-> inj_req_i);
endmodule

bind ring_stop ring_stop_chk #(.DATA_W(DATA_W), .NODES(NODES), .NODE_ID(NODE_ID)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .par_odd       (par_odd),
  .cw_in_vld_i   (cw_in_vld_i),
  .cw_in_dst_i   (cw_in_dst_i),
  .cw_in_dat_i   (cw_in_dat_i),
  .cw_out_vld_o  (cw_out_vld_o),
  .cw_out_dat_o  (cw_out_dat_o),
  .ccw_in_vld_i  (ccw_in_vld_i),
  .ccw_in_dst_i  (ccw_in_dst_i),
  .ccw_in_dat_i  (ccw_in_dat_i),
  .ccw_out_vld_o (ccw_out_vld_o),
  .ccw_out_dat_o (ccw_out_dat_o),
  .inj_req_i     (inj_req_i),
  .inj_ack_o     (inj_ack_o),
  .ej_vld_o      (ej_vld_o),
  .ej_dir_o      (ej_dir_o),
  .ej_dat_o      (ej_dat_o)
);

// File: tb/ring_stop_tb.sv
module ring_stop_tb;
  localparam int DW   = 512;
  localparam int NN   = 16;
  localparam int ME   = 5;
  localparam int IW   = $clog2(NN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cw_in_vld, ccw_in_vld, inj_req;
  logic [IW-1:0] cw_in_dst, ccw_in_dst, inj_dst;
  logic [DW-1:0] cw_in_dat, ccw_in_dat, inj_dat;
  logic          cw_out_vld, ccw_out_vld, inj_ack, ej_vld, ej_dir;
  logic [IW-1:0] cw_out_dst, ccw_out_dst;
  logic [DW-1:0] cw_out_dat, ccw_out_dat, ej_dat;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  ring_stop #(.DATA_W(DW), .NODES(NN), .NODE_ID(ME)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cw_in_vld_i(cw_in_vld), .cw_in_dst_i(cw_in_dst), .cw_in_dat_i(cw_in_dat),
    .cw_out_vld_o(cw_out_vld), .cw_out_dst_o(cw_out_dst), .cw_out_dat_o(cw_out_dat),
    .ccw_in_vld_i(ccw_in_vld), .ccw_in_dst_i(ccw_in_dst), .ccw_in_dat_i(ccw_in_dat),
    .ccw_out_vld_o(ccw_out_vld), .ccw_out_dst_o(ccw_out_dst), .ccw_out_dat_o(ccw_out_dat),
    .inj_req_i(inj_req), .inj_dst_i(inj_dst), .inj_dat_i(inj_dat), .inj_ack_o(inj_ack),
    .ej_vld_o(ej_vld), .ej_dir_o(ej_dir), .ej_dat_o(ej_dat)
  );

  // cycles since reset release; even cycles have cyc[0]==0 (R5)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic logic [DW-1:0] pat(input logic [31:0] w);
    return {16{w}};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cw_in_vld = 0; cw_in_dst = '0; cw_in_dat = '0;
    ccw_in_vld = 0; ccw_in_dst = '0; ccw_in_dat = '0;
    inj_req = 0; inj_dst = '0; inj_dat = '0;
  endtask

  task automatic to_parity(input bit odd);
    @(negedge clk);
    while (cyc[0] != odd) @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // first cycle after release must be even: clockwise local slot is delivered
    cw_in_vld = 1; cw_in_dst = IW'(ME); cw_in_dat = pat(32'h0000_0001);
    #1;
    chk("R5 even after reset", DW'(ej_vld), DW'(1));
    chk("R5 dir", DW'(ej_dir), DW'(0));
    chk("R2 cw out emptied", DW'(cw_out_vld), DW'(0));
  endtask

  task automatic t_pass();
    to_parity(0);
    cw_in_vld = 1; cw_in_dst = 4'd9; cw_in_dat = pat(32'h1111_2222);
    ccw_in_vld = 1; ccw_in_dst = 4'd2; ccw_in_dat = pat(32'h3333_4444);
    #1;
    chk("R1 cw vld", DW'(cw_out_vld), DW'(1));
    chk("R1 cw dst", DW'(cw_out_dst), DW'(9));
    chk("R1 cw dat", cw_out_dat, pat(32'h1111_2222));
    chk("R1 ccw dat", ccw_out_dat, pat(32'h3333_4444));
    chk("R1 no eject", DW'(ej_vld), DW'(0));
  endtask

  task automatic t_parity();
    to_parity(1);
    cw_in_vld = 1; cw_in_dst = IW'(ME); cw_in_dat = pat(32'hC0DE_0001);
    ccw_in_vld = 1; ccw_in_dst = IW'(ME); ccw_in_dat = pat(32'hC0DE_0002);
    #1;
    chk("R3 ccw odd eject", DW'({ej_vld, ej_dir}), DW'(2'b11));
    chk("R3 ccw dat", ej_dat, pat(32'hC0DE_0002));
    chk("R4 cw circulates vld", DW'(cw_out_vld), DW'(1));
    chk("R4 cw circulates dat", cw_out_dat, pat(32'hC0DE_0001));
    to_parity(0);
    cw_in_vld = 1; cw_in_dst = IW'(ME); cw_in_dat = pat(32'hC0DE_0003);
    ccw_in_vld = 1; ccw_in_dst = IW'(ME); ccw_in_dat = pat(32'hC0DE_0004);
    #1;
    chk("R2 cw even eject", DW'({ej_vld, ej_dir}), DW'(2'b10));
    chk("R2 cw dat", ej_dat, pat(32'hC0DE_0003));
    chk("R4 ccw circulates", ccw_out_dat, pat(32'hC0DE_0004));
    chk("R4 ccw vld", DW'(ccw_out_vld), DW'(1));
    chk("R5 parity alternates", DW'(cyc[0]), DW'(0));
  endtask

  task automatic t_route();
    to_parity(0);
    inj_req = 1; inj_dst = 4'd7; inj_dat = pat(32'hAAAA_0007);
    #1;
    chk("R6 dst7 cw ack", DW'(inj_ack), DW'(1));
    chk("R6 dst7 on cw", cw_out_dat, pat(32'hAAAA_0007));
    chk("R6 dst7 ccw idle", DW'(ccw_out_vld), DW'(0));
    inj_dst = 4'd3; inj_dat = pat(32'hAAAA_0003);
    #1;
    chk("R6 dst3 on ccw", DW'({ccw_out_vld, cw_out_vld}), DW'(2'b10));
    chk("R6 dst3 dst", DW'(ccw_out_dst), DW'(3));
    inj_dst = 4'd13; inj_dat = pat(32'hAAAA_000D);
    #1;
    chk("R6 tie cw", DW'({ccw_out_vld, cw_out_vld}), DW'(2'b01));
  endtask

  task automatic t_collide();
    to_parity(0);
    // refill of the slot just delivered (R8)
    cw_in_vld = 1; cw_in_dst = IW'(ME); cw_in_dat = pat(32'hBEEF_0001);
    inj_req = 1; inj_dst = 4'd7; inj_dat = pat(32'hFEED_0007);
    #1;
    chk("R8 eject dat", ej_dat, pat(32'hBEEF_0001));
    chk("R8 ack", DW'(inj_ack), DW'(1));
    chk("R8 cw carries new", cw_out_dat, pat(32'hFEED_0007));
    // passing slot blocks the send (R7)
    cw_in_dst = 4'd9; cw_in_dat = pat(32'hBEEF_0009);
    #1;
    chk("R7 stalled", DW'(inj_ack), DW'(0));
    chk("R7 passing kept", cw_out_dat, pat(32'hBEEF_0009));
    to_parity(1);
    // local slot on ineligible parity still blocks (R7)
    cw_in_vld = 1; cw_in_dst = IW'(ME); cw_in_dat = pat(32'hBEEF_0005);
    inj_req = 1; inj_dst = 4'd7; inj_dat = pat(32'hFEED_0008);
    #1;
    chk("R7 odd stall", DW'(inj_ack), DW'(0));
    chk("R7 odd kept", cw_out_dat, pat(32'hBEEF_0005));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pass();
        t_parity();
        t_route();
        t_collide();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule